// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block sits between instruction decode and issue and expands one scalar instruction into a run of element operations. On a start pulse it captures the vector length, the predicate mask, the zeroing choice and three tagged operand fields: one destination and two sources. It then holds the program counter and steps an element counter from 0 to VL-1, issuing one element per clock. For each element it presents the destination and source register numbers, a register-file write enable, and a flag that asks for the element to be written as zero.

Each operand is decoded on its own from a short register-number field plus a tag. The tag is either 3 bits wide, or 2 bits wide and moved up one place. The top tag bit decides between scalar and vector, and the two low tag bits widen the register number. A vector operand's register number starts at the base number moved up two places and steps by one per element. A scalar operand's register number takes the tag bits above the base number and never moves.

A scalar destination turns the loop into a search: the sources keep stepping until the first enabled element is written, and the run ends there. The arithmetic unit and the register file lie outside this block.

Top module: `vec_elem_seq`

## Requirements
- R1: Tag decode. The effective 3-bit tag is `spec` when `tag3_mode`=1, or `{spec[1:0],1'b0}` when it is 0. When effective bit 2 is 1 the operand is a vector with register `{base, tag[1:0]}`. Otherwise it is a scalar with register `{tag[1:0], base}`.
- R2: For a vector destination with VL in 1..64, exactly VL elements are issued on consecutive clocks with `el_idx` = 0..VL-1. The first element appears the clock after `start` is accepted.
- R3: A vector operand's register number equals its decoded base plus `el_idx`, modulo 128. A scalar operand's register number stays at its decoded base for every element.
- R4: When the predicate bit for an element is 0 and zeroing is off, `wr_en`=0 for that element, and all vector register numbers still advance.
- R5: When `pred_en`=0, `pred_mask` is ignored and every element is treated as enabled.
- R6: When zeroing is on, a masked-out element drives `wr_en`=1 and `wr_zero`=1. An enabled element always drives `wr_zero`=0.
- R7: With a scalar destination, the run ends after the first element whose predicate bit is 1, and that element is written. If no bit in 0..VL-1 is set, all VL elements are issued.
- R8: `busy` (hold the program counter) is 1 during every issued element. `done` is a one-clock pulse in the clock after the last element.
- R9: A start with VL=0 issues no element and pulses `done` in the next clock.
- R10: A `start` that arrives while `busy`=1 is ignored, and the run in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| vlen | input | 7 | Vector length, 0..64 |
| pred_en | input | 1 | Use `pred_mask`, else all ones |
| pred_mask | input | 64 | Per-element enable, bit i for element i |
| zero_en | input | 1 | Write zero for masked-out elements |
| tag3_mode | input | 1 | Tags are 3-bit (1) or 2-bit (0) |
| dst_base | input | 5 | Destination base number |
| dst_spec | input | 3 | Destination tag |
| sa_base | input | 5 | Source A base number |
| sa_spec | input | 3 | Source A tag |
| sb_base | input | 5 | Source B base number |
| sb_spec | input | 3 | Source B tag |
| busy | output | 1 | Run in progress; program counter held |
| el_valid | output | 1 | Element strobe |
| el_idx | output | 6 | Current element number |
| dst_reg | output | 7 | Destination register for this element |
| sa_reg | output | 7 | Source A register for this element |
| sb_reg | output | 7 | Source B register for this element |
| wr_en | output | 1 | Write the element result |
| wr_zero | output | 1 | The write carries zero |
| done | output | 1 | One-clock end-of-run pulse |

## Verification
A corrupted element counter shows up at once in the port stream. `el_idx` skips or repeats, and vector register numbers stop following the base plus the index, so the element-by-element comparison catches it in the first element after the fault. A wrong captured mask or zeroing bit shows up as a wrong `wr_en` or `wr_zero` on the affected element. A bad end-of-run condition shows up as extra or missing elements, or as a misplaced `done`, and is caught in the clock after the last expected element.

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int VL_MAX = 64,
  parameter int BASE_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [$clog2(VL_MAX):0]       vlen,
  input  logic                          pred_en,
  input  logic [VL_MAX-1:0]             pred_mask,
  input  logic                          zero_en,
  input  logic                          tag3_mode,
  input  logic [BASE_W-1:0]             dst_base,
  input  logic [2:0]                    dst_spec,
  input  logic [BASE_W-1:0]             sa_base,
  input  logic [2:0]                    sa_spec,
  input  logic [BASE_W-1:0]             sb_base,
  input  logic [2:0]                    sb_spec,
  output logic                          busy,
  output logic                          el_valid,
  output logic [$clog2(VL_MAX)-1:0]     el_idx,
  output logic [BASE_W+1:0]             dst_reg,
  output logic [BASE_W+1:0]             sa_reg,
  output logic [BASE_W+1:0]             sb_reg,
  output logic                          wr_en,
  output logic                          wr_zero,
  output logic                          done
);
  localparam int CNT_W = $clog2(VL_MAX);
  localparam int VL_W  = CNT_W + 1;
  localparam int REG_W = BASE_W + 2;

  function automatic logic [REG_W:0] decode_tag(input logic [BASE_W-1:0] base,
                                                input logic [2:0] spec,
                                                input logic mode3);
    logic [2:0] t;
    t = mode3 ? spec : {spec[1:0], 1'b0};
    if (t[2]) decode_tag = {1'b1, base, t[1:0]};
    else      decode_tag = {1'b0, t[1:0], base};
  endfunction

  logic [REG_W:0]     d_dec, a_dec, b_dec;
  logic [REG_W:0]     d_q, a_q, b_q;
  logic [VL_MAX-1:0]  mask_q;
  logic               zero_q;
  logic [VL_W-1:0]    vl_q;
  logic [CNT_W-1:0]   cnt;
  logic               run;
  logic               done_q;

  assign d_dec = decode_tag(dst_base, dst_spec, tag3_mode);
  assign a_dec = decode_tag(sa_base,  sa_spec,  tag3_mode);
  assign b_dec = decode_tag(sb_base,  sb_spec,  tag3_mode);

  logic [VL_W-1:0] vl_in;
  assign vl_in = (vlen > VL_W'(VL_MAX)) ? VL_W'(VL_MAX) : vlen;

  logic [REG_W-1:0] step;
  logic             bit_on;
  logic             last;
  assign step   = REG_W'(cnt);
  assign bit_on = mask_q[cnt];
  assign last   = (VL_W'(cnt) == vl_q - VL_W'(1)) || (!d_q[REG_W] && bit_on);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
      vl_q   <= '0;
      mask_q <= '0;
      zero_q <= 1'b0;
      d_q    <= '0;
      a_q    <= '0;
      b_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run && start) begin
        vl_q   <= vl_in;
        mask_q <= pred_en ? pred_mask : '1;
        zero_q <= zero_en;
        d_q    <= d_dec;
        a_q    <= a_dec;
        b_q    <= b_dec;
        cnt    <= '0;
        if (vl_in == '0) done_q <= 1'b1;
        else             run    <= 1'b1;
      end else if (run) begin
        if (last) begin
          run    <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign busy     = run;
  assign el_valid = run;
  assign done     = done_q;
  assign el_idx   = run ? cnt : '0;
  assign dst_reg  = run ? d_q[REG_W-1:0] + (d_q[REG_W] ? step : '0) : '0;
  assign sa_reg   = run ? a_q[REG_W-1:0] + (a_q[REG_W] ? step : '0) : '0;
  assign sb_reg   = run ? b_q[REG_W-1:0] + (b_q[REG_W] ? step : '0) : '0;
  assign wr_en    = run && (bit_on || zero_q);
  assign wr_zero  = run && !bit_on && zero_q;
endmodule

module vec_elem_seq_chk #(
  parameter int CNT_W = 6,
  parameter int REG_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             el_valid,
  input logic [CNT_W-1:0] el_idx,
  input logic [REG_W-1:0] dst_reg,
  input logic [REG_W-1:0] sa_reg,
  input logic [REG_W-1:0] sb_reg,
  input logic             wr_en,
  input logic             wr_zero,
  input logic             done
);
  assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && $past(el_valid) |-> el_idx == $past(el_idx) + CNT_W'(1));
  assert_first_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(el_valid) |-> el_idx == '0);
  assert_src_a_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && $past(el_valid) |-> sa_reg == $past(sa_reg) || sa_reg == $past(sa_reg) + REG_W'(1));
  assert_src_b_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && $past(el_valid) |-> sb_reg == $past(sb_reg) || sb_reg == $past(sb_reg) + REG_W'(1));
  assert_dst_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && $past(el_valid) |-> dst_reg == $past(dst_reg) || dst_reg == $past(dst_reg) + REG_W'(1));
  assert_write_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> el_valid);
  assert_zero_is_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_zero |-> wr_en);
  assert_hold_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid |-> busy);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !el_valid);
  assert_done_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_busy_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !done |=> busy || done);
endmodule

bind vec_elem_seq vec_elem_seq_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/test_vec_elem_seq.sv
module test_vec_elem_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [5:0] idx;
    logic [6:0] d, a, b;
    logic       we, wz;
  } elem_t;

  logic clk = 0, rst_n = 0, start = 0;
  logic [6:0] vlen = 0;
  logic pred_en = 0, zero_en = 0, tag3_mode = 0;
  logic [63:0] pred_mask = 0;
  logic [4:0] dst_base = 0, sa_base = 0, sb_base = 0;
  logic [2:0] dst_spec = 0, sa_spec = 0, sb_spec = 0;
  logic busy, el_valid, wr_en, wr_zero, done;
  logic [5:0] el_idx;
  logic [6:0] dst_reg, sa_reg, sb_reg;

  int nchk = 0, nerr = 0;
  elem_t exp_q[$];
  string tag_q[$];
  string cur_tag = "";
  bit pend = 0;

  vec_elem_seq i_vec_elem_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bdec(input logic [4:0] base, input logic [2:0] spec, input logic m3);
    logic [2:0] t;
    t = m3 ? spec : {spec[1:0], 1'b0};
    return t[2] ? {1'b1, base, t[1:0]} : {1'b0, t[1:0], base};
  endfunction

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp, input string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && el_valid) begin
      if (exp_q.size() == 0) begin
        check(cur_tag, 1, 0, "unexpected element");
      end else begin
        elem_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {25'd0, el_idx, busy}, {25'd0, e.idx, 1'b1}, "idx/busy");
        check(t, {11'd0, dst_reg, sa_reg, sb_reg}, {11'd0, e.d, e.a, e.b}, "dst/srcA/srcB regs");
        check(t, {30'd0, wr_en, wr_zero}, {30'd0, e.we, e.wz}, "wr_en/wr_zero");
      end
    end
    if (rst_n && done) begin
      check(cur_tag, {31'd0, pend}, 1, "done without pending run");
      check(cur_tag, exp_q.size(), 0, "elements missing at done");
      check(cur_tag, {31'd0, el_valid}, 0, "element with done");
      pend = 0;
    end
  end

  task automatic run_op(input string r, input int vl, input logic pe, input logic [63:0] pm,
                        input logic z, input logic m3,
                        input logic [4:0] db, input logic [2:0] ds,
                        input logic [4:0] ab, input logic [2:0] as_,
                        input logic [4:0] bb, input logic [2:0] bs, input bit intrude);
    logic [7:0] dd, ad, bd;
    int waited;
    dd = bdec(db, ds, m3); ad = bdec(ab, as_, m3); bd = bdec(bb, bs, m3);
    for (int i = 0; i < vl; i++) begin
      elem_t e;
      logic m;
      m = pe ? pm[i] : 1'b1;
      e.idx = 6'(i);
      e.d = dd[7] ? dd[6:0] + 7'(i) : dd[6:0];
      e.a = ad[7] ? ad[6:0] + 7'(i) : ad[6:0];
      e.b = bd[7] ? bd[6:0] + 7'(i) : bd[6:0];
      e.we = m | z;
      e.wz = !m & z;
      exp_q.push_back(e);
      tag_q.push_back(r);
      if (!dd[7] && m) break;
    end
    cur_tag = r;
    pend = 1;
    @(negedge clk);
    start = 1; vlen = 7'(vl); pred_en = pe; pred_mask = pm; zero_en = z; tag3_mode = m3;
    dst_base = db; dst_spec = ds; sa_base = ab; sa_spec = as_; sb_base = bb; sb_spec = bs;
    @(negedge clk);
    start = 0;
    if (intrude) begin
      @(negedge clk);
      start = 1; vlen = 7'd40; pred_en = 0; zero_en = 1; dst_spec = 3'b000;
      dst_base = 5'd3; sa_base = 5'd9; sb_base = 5'd11;
      @(negedge clk);
      start = 0;
    end
    waited = 0;
    while (pend && waited < 300) begin
      @(posedge clk);
      waited++;
    end
    if (pend) begin
      check(r, 1, 0, "watchdog: no done");
      pend = 0;
      exp_q.delete();
      tag_q.delete();
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check("watchdog", 1, 0, "run timed out");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8: idle after reset
    check("R8", {29'd0, busy, el_valid, done}, 0, "reset state");
    // R1 R2 R3 R5: all vector, 3-bit tags, no predicate
    run_op("R5", 5, 0, 64'h0, 0, 1, 5'd2, 3'b101, 5'd7, 3'b110, 5'd1, 3'b100, 0);
    // R1 R4: 2-bit tags, source B scalar, mask 1010
    run_op("R4", 4, 1, 64'hA, 0, 0, 5'd4, 3'b010, 5'd6, 3'b011, 5'd9, 3'b001, 0);
    // R6: zeroing with mask 100101
    run_op("R6", 6, 1, 64'h25, 1, 1, 5'd8, 3'b111, 5'd3, 3'b100, 5'd30, 3'b011, 0);
    // R7: scalar dest stops at bit 3
    run_op("R7", 8, 1, 64'h08, 0, 1, 5'd5, 3'b010, 5'd2, 3'b101, 5'd12, 3'b110, 0);
    // R7: scalar dest, no bit set, full length
    run_op("R7", 3, 1, 64'h0, 0, 1, 5'd5, 3'b001, 5'd2, 3'b101, 5'd12, 3'b000, 0);
    // R7 R6: scalar dest with zeroing, stops at bit 2
    run_op("R7", 5, 1, 64'h4, 1, 1, 5'd17, 3'b000, 5'd2, 3'b100, 5'd1, 3'b111, 0);
    // R9: empty run
    run_op("R9", 0, 0, 64'h0, 0, 1, 5'd1, 3'b100, 5'd1, 3'b100, 5'd1, 3'b100, 0);
    // R2: longest run with register wrap
    run_op("R2", 64, 0, 64'h0, 0, 1, 5'd31, 3'b111, 5'd16, 3'b100, 5'd0, 3'b011, 0);
    // R10: second start during run is ignored
    run_op("R10", 6, 1, 64'h3B, 0, 1, 5'd10, 3'b100, 5'd20, 3'b101, 5'd0, 3'b010, 1);
    // R9: back-to-back after a run still idle
    check("R10", {30'd0, busy, el_valid}, 0, "idle after run");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule